// File: doc/BRIEF.md
# Bridge Address Window Translator

This block sits between a processor-side bus and a downstream bus and decides which processor accesses the bridge claims. It holds one programmable window for each of four downstream address spaces: memory, I/O, configuration and special. Each window records a parent-side base, a child-side base and a size. An access that falls entirely inside a window is claimed, and its address is moved from the parent range into the child range.

Software loads the windows once through a single-cycle programming port. Each slot accepts only its first non-empty programming. Lookups are combinational, so the chosen space and the translated address are ready in the same cycle as the access. The claim flag, the transferred byte count and the error flags are registered and appear one cycle later.

A separate check port screens upstream DMA requests. Only memory-space requests are accepted. A request whose start or end lands on the bridge's own memory child range is refused. Every other request is forwarded to the parent bus with its address unchanged.

Top module: `brx_xlate`

## Requirements
- R1: While rst_ni is low, every slot becomes empty and every registered output (claim, byte count, all error flags, DMA forward flag and DMA address) is zero.
- R2: Slot indices are 0 = memory, 1 = I/O, 2 = config and 3 = special. A programming request with an index of 4 to 7 raises prog_slot_err_o in the next cycle and loads nothing.
- R3: Programming a slot that is already loaded raises prog_dup_err_o in the next cycle and leaves that window unchanged. Programming an empty slot with size zero leaves the slot empty and raises no error.
- R4: An access matches a loaded window only when addr >= parent base and addr + len <= parent base + size. Both sums are taken one bit wider than the address, so they cannot wrap.
- R5: For a matching window, acc_xaddr_o = addr - parent base + child base, taken modulo 2^ADDR_W, in the same cycle as the access.
- R6: When several windows match, the slot with the lowest index wins. acc_space_o carries its index, in the same cycle as the access.
- R7: One cycle after an access with acc_valid_i high, acc_claim_o shows whether any window matched. acc_bytes_o then equals len when the access was claimed and 0 otherwise. Without acc_valid_i, nothing is claimed in the next cycle.
- R8: An access made while no slot is loaded raises acc_nowin_err_o in the next cycle and is not claimed.
- R9: A DMA request for any space other than 0 (memory) raises dma_space_err_o in the next cycle and is not forwarded.
- R10: A memory-space DMA request raises dma_own_err_o in the next cycle when either addr or addr + len lies in the closed range from child base to child base + size of the memory window. An empty memory slot never causes this refusal.
- R11: A memory-space DMA request that is not refused sets dma_fwd_o in the next cycle, and dma_addr_o then equals the request address. At most one of dma_fwd_o, dma_space_err_o and dma_own_err_o is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prog_valid_i | input | 1 | Programming request strobe |
| prog_slot_i | input | 3 | Target slot index |
| prog_parent_base_i | input | ADDR_W | Parent-side window base |
| prog_child_base_i | input | ADDR_W | Child-side window base |
| prog_size_i | input | ADDR_W | Window size in bytes |
| prog_slot_err_o | output | 1 | Slot index out of range |
| prog_dup_err_o | output | 1 | Slot already loaded |
| acc_valid_i | input | 1 | Access strobe |
| acc_addr_i | input | ADDR_W | Parent-side access address |
| acc_len_i | input | LEN_W | Access byte count |
| acc_space_o | output | 2 | Index of the matching slot |
| acc_xaddr_o | output | ADDR_W | Translated child-side address |
| acc_claim_o | output | 1 | Access claimed (registered) |
| acc_bytes_o | output | LEN_W | Bytes transferred (registered) |
| acc_nowin_err_o | output | 1 | Access made with no window loaded |
| dma_valid_i | input | 1 | DMA request strobe |
| dma_space_i | input | 2 | Requested space index |
| dma_addr_i | input | ADDR_W | DMA start address |
| dma_len_i | input | LEN_W | DMA byte count |
| dma_fwd_o | output | 1 | Request forwarded to the parent bus |
| dma_addr_o | output | ADDR_W | Forwarded address |
| dma_space_err_o | output | 1 | Non-memory DMA space |
| dma_own_err_o | output | 1 | DMA overlaps own memory window |

## Verification
Access addresses are swept one by one across each window's lower and upper edges, with several lengths. This separates the inclusive end test from an off-by-one one, and whole-access containment from a start-only test. A sweep across the region where the memory and config windows overlap shows whether lowest-slot priority holds, and a window ending at the top of the address space shows whether the end sum is taken wide enough to avoid wrapping. DMA start addresses are swept around both ends of the memory child range, with lengths of zero, one and the maximum. This tells the inclusive start and end overlap tests apart from a plain interval-intersection test. Invalid, duplicate and zero-size programming requests are each followed by accesses that would reveal any window they changed.

// File: rtl/brx_pkg.sv
package brx_pkg;
  localparam int unsigned NUM_SLOTS = 4;
  localparam int unsigned SLOT_W    = 2;
  localparam int unsigned PSLOT_W   = 3;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_MEM = 2'd0,
    SLOT_IO  = 2'd1,
    SLOT_CFG = 2'd2,
    SLOT_SPC = 2'd3
  } slot_e;
endpackage

// File: rtl/brx_window_bank.sv
module brx_window_bank
  import brx_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              prog_valid_i,
  input  logic [PSLOT_W-1:0]                prog_slot_i,
  input  logic [ADDR_W-1:0]                 prog_parent_base_i,
  input  logic [ADDR_W-1:0]                 prog_child_base_i,
  input  logic [ADDR_W-1:0]                 prog_size_i,
  output logic [NUM_SLOTS-1:0][ADDR_W-1:0]  pbase_o,
  output logic [NUM_SLOTS-1:0][ADDR_W-1:0]  cbase_o,
  output logic [NUM_SLOTS-1:0][ADDR_W-1:0]  size_o,
  output logic [NUM_SLOTS-1:0]              valid_o,
  output logic                              slot_err_o,
  output logic                              dup_err_o
);
  logic in_range;
  logic size_nz;
  logic [NUM_SLOTS-1:0] sel;

  assign in_range = (prog_slot_i < PSLOT_W'(NUM_SLOTS));
  assign size_nz  = (prog_size_i != '0);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign sel[i] = prog_valid_i && (prog_slot_i == PSLOT_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[i] <= 1'b0;
        pbase_o[i] <= '0;
        cbase_o[i] <= '0;
        size_o[i]  <= '0;
      end else if (sel[i] && !valid_o[i] && size_nz) begin
        valid_o[i] <= 1'b1;
        pbase_o[i] <= prog_parent_base_i;
        cbase_o[i] <= prog_child_base_i;
        size_o[i]  <= prog_size_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_err_o <= 1'b0;
      dup_err_o  <= 1'b0;
    end else begin
      slot_err_o <= prog_valid_i && !in_range;
      dup_err_o  <= |(sel & valid_o);
    end
  end
endmodule

// File: rtl/brx_lookup.sv
module brx_lookup
  import brx_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 8
) (
  input  logic [NUM_SLOTS-1:0][ADDR_W-1:0] pbase_i,
  input  logic [NUM_SLOTS-1:0][ADDR_W-1:0] cbase_i,
  input  logic [NUM_SLOTS-1:0][ADDR_W-1:0] size_i,
  input  logic [NUM_SLOTS-1:0]             valid_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [LEN_W-1:0]                 len_i,
  output logic                             hit_o,
  output logic [SLOT_W-1:0]                slot_o,
  output logic [ADDR_W-1:0]                xaddr_o
);
  localparam int unsigned EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] acc_lo;
  logic [EXT_W-1:0] acc_hi;
  logic [NUM_SLOTS-1:0] match;

  assign acc_lo = {1'b0, addr_i};
  assign acc_hi = acc_lo + EXT_W'(len_i);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cmp
    logic [EXT_W-1:0] win_lo;
    logic [EXT_W-1:0] win_hi;
    assign win_lo   = {1'b0, pbase_i[i]};
    assign win_hi   = win_lo + {1'b0, size_i[i]};
    assign match[i] = valid_i[i] && (acc_lo >= win_lo) && (acc_hi <= win_hi);
  end

  // lowest index wins: scan downwards, last assignment sticks
  always_comb begin
    hit_o  = 1'b0;
    slot_o = '0;
    for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
      if (match[k]) begin
        hit_o  = 1'b1;
        slot_o = SLOT_W'(k);
      end
    end
  end

  assign xaddr_o = addr_i - pbase_i[slot_o] + cbase_i[slot_o];
endmodule

// File: rtl/brx_dma_guard.sv
module brx_dma_guard
  import brx_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 8
) (
  input  logic [ADDR_W-1:0] mem_cbase_i,
  input  logic [ADDR_W-1:0] mem_size_i,
  input  logic              mem_valid_i,
  input  logic              dma_valid_i,
  input  logic [SLOT_W-1:0] dma_space_i,
  input  logic [ADDR_W-1:0] dma_addr_i,
  input  logic [LEN_W-1:0]  dma_len_i,
  output logic              fwd_o,
  output logic              space_bad_o,
  output logic              own_hit_o
);
  localparam int unsigned EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] lo, hi, s, e;
  logic is_mem, s_in, e_in;

  assign lo     = {1'b0, mem_cbase_i};
  assign hi     = lo + {1'b0, mem_size_i};
  assign s      = {1'b0, dma_addr_i};
  assign e      = s + EXT_W'(dma_len_i);
  assign s_in   = (s >= lo) && (s <= hi);
  assign e_in   = (e >= lo) && (e <= hi);
  assign is_mem = (dma_space_i == SLOT_MEM);

  assign space_bad_o = dma_valid_i && !is_mem;
  assign own_hit_o   = dma_valid_i && is_mem && mem_valid_i && (s_in || e_in);
  assign fwd_o       = dma_valid_i && is_mem && !own_hit_o;
endmodule

// File: rtl/brx_xlate.sv
module brx_xlate
  import brx_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                prog_valid_i,
  input  logic [2:0]          prog_slot_i,
  input  logic [ADDR_W-1:0]   prog_parent_base_i,
  input  logic [ADDR_W-1:0]   prog_child_base_i,
  input  logic [ADDR_W-1:0]   prog_size_i,
  output logic                prog_slot_err_o,
  output logic                prog_dup_err_o,
  input  logic                acc_valid_i,
  input  logic [ADDR_W-1:0]   acc_addr_i,
  input  logic [LEN_W-1:0]    acc_len_i,
  output logic [1:0]          acc_space_o,
  output logic [ADDR_W-1:0]   acc_xaddr_o,
  output logic                acc_claim_o,
  output logic [LEN_W-1:0]    acc_bytes_o,
  output logic                acc_nowin_err_o,
  input  logic                dma_valid_i,
  input  logic [1:0]          dma_space_i,
  input  logic [ADDR_W-1:0]   dma_addr_i,
  input  logic [LEN_W-1:0]    dma_len_i,
  output logic                dma_fwd_o,
  output logic [ADDR_W-1:0]   dma_addr_o,
  output logic                dma_space_err_o,
  output logic                dma_own_err_o
);
  logic [NUM_SLOTS-1:0][ADDR_W-1:0] win_pb, win_cb, win_sz;
  logic [NUM_SLOTS-1:0]             win_v;
  logic                             lk_hit;
  logic                             any_win;
  logic                             dg_fwd, dg_bad, dg_own;

  brx_window_bank #(.ADDR_W(ADDR_W)) i_bank (
    .clk_i              (clk_i),
    .rst_ni             (rst_ni),
    .prog_valid_i       (prog_valid_i),
    .prog_slot_i        (prog_slot_i),
    .prog_parent_base_i (prog_parent_base_i),
    .prog_child_base_i  (prog_child_base_i),
    .prog_size_i        (prog_size_i),
    .pbase_o            (win_pb),
    .cbase_o            (win_cb),
    .size_o             (win_sz),
    .valid_o            (win_v),
    .slot_err_o         (prog_slot_err_o),
    .dup_err_o          (prog_dup_err_o)
  );

  brx_lookup #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_lookup (
    .pbase_i (win_pb),
    .cbase_i (win_cb),
    .size_i  (win_sz),
    .valid_i (win_v),
    .addr_i  (acc_addr_i),
    .len_i   (acc_len_i),
    .hit_o   (lk_hit),
    .slot_o  (acc_space_o),
    .xaddr_o (acc_xaddr_o)
  );

  brx_dma_guard #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_dma (
    .mem_cbase_i (win_cb[SLOT_MEM]),
    .mem_size_i  (win_sz[SLOT_MEM]),
    .mem_valid_i (win_v[SLOT_MEM]),
    .dma_valid_i (dma_valid_i),
    .dma_space_i (dma_space_i),
    .dma_addr_i  (dma_addr_i),
    .dma_len_i   (dma_len_i),
    .fwd_o       (dg_fwd),
    .space_bad_o (dg_bad),
    .own_hit_o   (dg_own)
  );

  assign any_win = |win_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_claim_o     <= 1'b0;
      acc_bytes_o     <= '0;
      acc_nowin_err_o <= 1'b0;
      dma_fwd_o       <= 1'b0;
      dma_addr_o      <= '0;
      dma_space_err_o <= 1'b0;
      dma_own_err_o   <= 1'b0;
    end else begin
      acc_claim_o     <= acc_valid_i && lk_hit;
      acc_bytes_o     <= (acc_valid_i && lk_hit) ? acc_len_i : '0;
      acc_nowin_err_o <= acc_valid_i && !any_win;
      dma_fwd_o       <= dg_fwd;
      dma_addr_o      <= dg_fwd ? dma_addr_i : '0;
      dma_space_err_o <= dg_bad;
      dma_own_err_o   <= dg_own;
    end
  end
endmodule

// File: rtl/brx_xlate_chk.sv
module brx_xlate_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              prog_valid_i,
  input logic [2:0]        prog_slot_i,
  input logic              prog_slot_err_o,
  input logic              acc_valid_i,
  input logic              lk_hit,
  input logic              acc_claim_o,
  input logic [LEN_W-1:0]  acc_bytes_o,
  input logic              acc_nowin_err_o,
  input logic              dma_valid_i,
  input logic [1:0]        dma_space_i,
  input logic [ADDR_W-1:0] dma_addr_i,
  input logic              dma_fwd_o,
  input logic [ADDR_W-1:0] dma_addr_o,
  input logic              dma_space_err_o,
  input logic              dma_own_err_o
);
  // R2
  bad_slot_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_valid_i && prog_slot_i > 3'd3) |=> prog_slot_err_o);

  // R7
  idle_no_claim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> !acc_claim_o);

  // R7
  hit_claims_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && lk_hit) |=> acc_claim_o);

  // R7
  unclaimed_zero_bytes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_claim_o |-> (acc_bytes_o == '0));

  // R8
  nowin_excl_claim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_claim_o |-> !acc_nowin_err_o);

  // R9
  dma_space_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_valid_i && dma_space_i != 2'd0) |=> (dma_space_err_o && !dma_fwd_o));

  // R11
  dma_outcome_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dma_fwd_o, dma_space_err_o, dma_own_err_o}));

  // R11
  dma_addr_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_fwd_o |-> (dma_addr_o == $past(dma_addr_i)));
endmodule

bind brx_xlate brx_xlate_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_chk (.*);

// File: tb/test_brx_xlate.sv
`timescale 1ns/1ps
module test_brx_xlate;
  localparam int unsigned AW = 16;
  localparam int unsigned LW = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          prog_valid_i = 1'b0;
  logic [2:0]    prog_slot_i = '0;
  logic [AW-1:0] prog_parent_base_i = '0, prog_child_base_i = '0, prog_size_i = '0;
  logic          prog_slot_err_o, prog_dup_err_o;
  logic          acc_valid_i = 1'b0;
  logic [AW-1:0] acc_addr_i = '0;
  logic [LW-1:0] acc_len_i = '0;
  logic [1:0]    acc_space_o;
  logic [AW-1:0] acc_xaddr_o;
  logic          acc_claim_o;
  logic [LW-1:0] acc_bytes_o;
  logic          acc_nowin_err_o;
  logic          dma_valid_i = 1'b0;
  logic [1:0]    dma_space_i = '0;
  logic [AW-1:0] dma_addr_i = '0;
  logic [LW-1:0] dma_len_i = '0;
  logic          dma_fwd_o;
  logic [AW-1:0] dma_addr_o;
  logic          dma_space_err_o, dma_own_err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_pb [4];
  logic [AW-1:0] m_cb [4];
  logic [AW-1:0] m_sz [4];
  bit            m_v  [4];

  always #2.5 clk = ~clk;

  brx_xlate #(.ADDR_W(AW), .LEN_W(LW)) i_brx_xlate (.clk_i(clk), .*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic prog(input logic [2:0] s, input logic [AW-1:0] pb, cb, sz,
                      input bit exp_slot, input bit exp_dup);
    @(negedge clk);
    prog_valid_i = 1'b1; prog_slot_i = s;
    prog_parent_base_i = pb; prog_child_base_i = cb; prog_size_i = sz;
    @(posedge clk); #1;
    prog_valid_i = 1'b0;
    chk("R2 slot_err", 32'(prog_slot_err_o), 32'(exp_slot));
    chk("R3 dup_err", 32'(prog_dup_err_o), 32'(exp_dup));
    if (s < 3'd4 && !m_v[s[1:0]] && sz != '0) begin
      m_v[s[1:0]] = 1'b1; m_pb[s[1:0]] = pb; m_cb[s[1:0]] = cb; m_sz[s[1:0]] = sz;
    end
  endtask

  task automatic access(input logic [AW-1:0] a, input logic [LW-1:0] l);
    bit hit = 1'b0;
    bit anyw = 1'b0;
    int sl = 0;
    logic [AW:0] e = {1'b0, a} + (AW+1)'(l);
    for (int k = 3; k >= 0; k--) begin
      if (m_v[k]) anyw = 1'b1;
      if (m_v[k] && {1'b0, a} >= {1'b0, m_pb[k]} && e <= ({1'b0, m_pb[k]} + {1'b0, m_sz[k]})) begin
        hit = 1'b1; sl = k;
      end
    end
    @(negedge clk);
    acc_valid_i = 1'b1; acc_addr_i = a; acc_len_i = l;
    #1;
    if (hit) begin
      chk("R6 space", 32'(acc_space_o), 32'(sl));
      chk("R5 xaddr", 32'(acc_xaddr_o), 32'(AW'(a - m_pb[sl] + m_cb[sl])));
    end
    @(posedge clk); #1;
    acc_valid_i = 1'b0;
    chk("R4 claim", 32'(acc_claim_o), 32'(hit));
    chk("R7 bytes", 32'(acc_bytes_o), hit ? 32'(l) : 32'd0);
    chk("R8 nowin", 32'(acc_nowin_err_o), 32'(!anyw));
  endtask

  task automatic dma(input logic [1:0] sp, input logic [AW-1:0] a, input logic [LW-1:0] l);
    logic [AW:0] s = {1'b0, a};
    logic [AW:0] e = {1'b0, a} + (AW+1)'(l);
    logic [AW:0] lo = {1'b0, m_cb[0]};
    logic [AW:0] hi = {1'b0, m_cb[0]} + {1'b0, m_sz[0]};
    bit bad = (sp != 2'd0);
    bit own = !bad && m_v[0] && ((s >= lo && s <= hi) || (e >= lo && e <= hi));
    bit fwd = !bad && !own;
    @(negedge clk);
    dma_valid_i = 1'b1; dma_space_i = sp; dma_addr_i = a; dma_len_i = l;
    @(posedge clk); #1;
    dma_valid_i = 1'b0;
    chk("R9 space_err", 32'(dma_space_err_o), 32'(bad));
    chk("R10 own_err", 32'(dma_own_err_o), 32'(own));
    chk("R11 fwd", 32'(dma_fwd_o), 32'(fwd));
    if (fwd) chk("R11 addr", 32'(dma_addr_o), 32'(a));
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 4; k++) begin
      m_v[k] = 1'b0; m_pb[k] = '0; m_cb[k] = '0; m_sz[k] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 claim", 32'(acc_claim_o), 0);
    chk("R1 bytes", 32'(acc_bytes_o), 0);
    chk("R1 nowin", 32'(acc_nowin_err_o), 0);
    chk("R1 dma", 32'({dma_fwd_o, dma_space_err_o, dma_own_err_o, prog_slot_err_o, prog_dup_err_o}), 0);
    chk("R1 dma_addr", 32'(dma_addr_o), 0);
    @(negedge clk); rst_ni = 1'b1;

    access(16'h1000, 4'd4);                       // R8 no windows
    dma(2'd0, 16'h8050, 4'd4);                    // R10 empty memory slot forwards
    prog(3'd6, 16'h4000, 16'h0, 16'h100, 1'b1, 1'b0); // R2
    prog(3'd4, 16'h4000, 16'h0, 16'h100, 1'b1, 1'b0); // R2
    prog(3'd1, 16'h2000, 16'h0, 16'h0, 1'b0, 1'b0);   // R3 zero size
    access(16'h4000, 4'd1);                       // R2 nothing loaded
    access(16'h2000, 4'd1);                       // R3 slot still empty

    prog(3'd0, 16'h1000, 16'h8000, 16'h0100, 1'b0, 1'b0);
    prog(3'd1, 16'h2000, 16'h0000, 16'h0040, 1'b0, 1'b0);
    prog(3'd2, 16'h1080, 16'h0300, 16'h0100, 1'b0, 1'b0);
    prog(3'd3, 16'hFFF0, 16'h0010, 16'h0010, 1'b0, 1'b0);
    prog(3'd0, 16'h3000, 16'h5000, 16'h0100, 1'b0, 1'b1); // R3 duplicate
    prog(3'd2, 16'h3000, 16'h5000, 16'h0000, 1'b0, 1'b1); // R3 duplicate
    access(16'h3000, 4'd1);                       // R3 duplicate ignored

    // R7 idle cycle
    @(posedge clk); #1;
    chk("R7 idle claim", 32'(acc_claim_o), 0);

    // R4 R5 R6 sweeps
    for (int a = 16'h0FF8; a <= 16'h1190; a++) begin
      access(AW'(a), 4'd1);
      access(AW'(a), 4'd8);
      access(AW'(a), 4'd0);
    end
    for (int a = 16'h1FF0; a <= 16'h2048; a++) begin
      access(AW'(a), 4'd2);
      access(AW'(a), 4'd15);
    end
    for (int a = 16'hFFE0; a <= 16'hFFFF; a++) begin
      for (int l = 0; l < 16; l++) access(AW'(a), LW'(l));
    end

    // R9 R10 R11 DMA sweeps
    for (int sp = 1; sp < 4; sp++) dma(2'(sp), 16'h8000, 4'd1);
    for (int a = 16'h7FE8; a <= 16'h8110; a++) begin
      dma(2'd0, AW'(a), 4'd0);
      dma(2'd0, AW'(a), 4'd1);
      dma(2'd0, AW'(a), 4'd15);
    end
    dma(2'd0, 16'h0000, 4'd4);
    dma(2'd0, 16'hFFFF, 4'd15);

    finish_run();
  end
endmodule